// File: doc/BRIEF.md
# Relocatable Configuration Register Window

This block is a memory-mapped configuration register file. It occupies a 1 MiB window on a 32-bit address bus. The window comes out of reset at 0xFF70_0000. Software can move the whole window to any other 1 MiB-aligned location by writing the window's own base register. Every bus access is compared against the current base. A matching access is claimed and answered one cycle later. A non-matching access gets no answer.

Inside the window the block serves a handful of registers:
- a chip-select bounds and config pair, derived from a memory-size configuration input;
- a pair of memory error registers, one always reading zero and one storing a masked value;
- a PLL status strap;
- processor and system version values, taken from inputs;
- a reset-control register that raises a one-cycle system-reset request.

The block also drives the address of the interrupt-acknowledge register. That address always sits at a fixed distance above the current base, so it moves whenever the window moves.

Top module: `relocwin_top`

## Requirements
- R1: After reset the base is 0xFF70_0000, the interrupt-acknowledge address is 0xFF74_00A0, the error disable register reads 0, and no response or reset request is active.
- R2: An access with busValid high is claimed only when busAddr[31:20] equals the current base[31:20]. A claimed access raises rspValid for exactly the next cycle. Reads put their data on rspData, and writes return rspData = 0. Unclaimed accesses raise no rspValid.
- R3: A read of offset 0x00000 (busAddr[19:0]) returns the current base shifted right by 12.
- R4: A write to offset 0x00000 sets the base to (busWdata AND 0x000F_FF00) shifted left by 12. An access in the very next cycle is decoded against the new base, and the old window no longer claims.
- R5: iackAddr equals base + 0x0004_00A0 at all times. It changes in the same cycle as the base.
- R6: A read of offset 0x02000 returns (memSize − 1) shifted right by 24, using 32-bit unsigned wrap-around.
- R7: A read of offset 0x02080 returns 0x8000_0000.
- R8: A read of offset 0x02E40 returns 0. A write to offset 0x02E44 stores busWdata AND 0xD, and a read of 0x02E44 returns the stored value.
- R9: Reads of offset 0xE0000 return pllStrap, 0xE00A0 returns procVer, and 0xE00A4 returns sysVer.
- R10: A write to offset 0xE00B0 with busWdata bit 1 set drives sysRstReq high for exactly the cycle after the write. A write with bit 1 clear causes no pulse. Reads of this offset return 0.
- R11: Inside the window, reads of any other offset return 0 and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 32 | Byte address of the access |
| busWdata | input | 32 | Write data |
| memSize | input | 32 | Memory size configuration in bytes |
| pllStrap | input | 32 | PLL status strap value |
| procVer | input | 32 | Processor version value |
| sysVer | input | 32 | System version value |
| rspValid | output | 1 | Response for the access claimed in the previous cycle |
| rspData | output | 32 | Read data of that response (0 for writes) |
| iackAddr | output | 32 | Address of the interrupt-acknowledge register |
| sysRstReq | output | 1 | One-cycle system-reset request |

## Verification
The bench relocates the window and reads the new location in the very next cycle.
- A design that commits the base late would miss that access.
- A design that still decodes against the old base would keep claiming the old window.

The bench checks iackAddr right after relocation, which catches an interrupt-acknowledge address left behind at the old base. It writes the reset-control register with bit 1 set and with bit 1 clear, to expose a stuck or spurious reset request. Masking of the error disable register and of the base write is checked with all-ones and scattered data. Bounds reads at the extreme sizes, including zero, expose a wrong shift or a missing wrap-around.

// File: rtl/relocwin_pkg.sv
package relocwin_pkg;

  localparam logic [19:0] OFS_BASE   = 20'h00000;
  localparam logic [19:0] OFS_BNDS   = 20'h02000;
  localparam logic [19:0] OFS_CSCFG  = 20'h02080;
  localparam logic [19:0] OFS_ERRDET = 20'h02E40;
  localparam logic [19:0] OFS_ERRDIS = 20'h02E44;
  localparam logic [19:0] OFS_PLL    = 20'hE0000;
  localparam logic [19:0] OFS_PVER   = 20'hE00A0;
  localparam logic [19:0] OFS_SVER   = 20'hE00A4;
  localparam logic [19:0] OFS_RSTC   = 20'hE00B0;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_BASE, SEL_BNDS, SEL_CSCFG, SEL_ERRDET,
    SEL_ERRDIS, SEL_PLL, SEL_PVER, SEL_SVER, SEL_RSTC
  } rdSel_e;

  typedef struct packed {
    logic   claim;
    logic   isWrite;
    logic   baseWr;
    logic   errDisWr;
    logic   rstWr;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/relocwin_ctrl.sv
module relocwin_ctrl
  import relocwin_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WIN_BITS = 20
) (
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [ADDR_W-1:0] curBase,
  output strobe_t           strb
);
  localparam int TAG_W = ADDR_W - WIN_BITS;

  logic [TAG_W-1:0]    addrTag;
  logic [TAG_W-1:0]    baseTag;
  logic [WIN_BITS-1:0] offset;
  logic [19:0]         ofs20;
  logic                hit;
  rdSel_e              sel;

  assign addrTag = busAddr[ADDR_W-1:WIN_BITS];
  assign baseTag = curBase[ADDR_W-1:WIN_BITS];
  assign offset  = busAddr[WIN_BITS-1:0];
  assign hit     = busValid && (addrTag == baseTag);

  generate
    if (WIN_BITS >= 20) begin : g_wide
      assign ofs20 = offset[19:0];
    end else begin : g_narrow
      assign ofs20 = {{(20-WIN_BITS){1'b0}}, offset};
    end
  endgenerate

  always_comb begin
    unique case (ofs20)
      OFS_BASE:   sel = SEL_BASE;
      OFS_BNDS:   sel = SEL_BNDS;
      OFS_CSCFG:  sel = SEL_CSCFG;
      OFS_ERRDET: sel = SEL_ERRDET;
      OFS_ERRDIS: sel = SEL_ERRDIS;
      OFS_PLL:    sel = SEL_PLL;
      OFS_PVER:   sel = SEL_PVER;
      OFS_SVER:   sel = SEL_SVER;
      OFS_RSTC:   sel = SEL_RSTC;
      default:    sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb.claim    = hit;
    strb.isWrite  = hit && busWrite;
    strb.baseWr   = hit && busWrite && (sel == SEL_BASE);
    strb.errDisWr = hit && busWrite && (sel == SEL_ERRDIS);
    strb.rstWr    = hit && busWrite && (sel == SEL_RSTC);
    strb.rdSel    = (hit && !busWrite) ? sel : SEL_NONE;
  end

endmodule

// File: rtl/relocwin_dp.sv
module relocwin_dp
  import relocwin_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              BASE_SHIFT = 12,
  parameter int              BNDS_SHIFT = 24,
  parameter logic [31:0]     RESET_BASE = 32'hFF70_0000,
  parameter logic [31:0]     BASE_MASK  = 32'h000F_FF00,
  parameter logic [31:0]     IACK_OFS   = 32'h0004_00A0,
  parameter logic [31:0]     ERRDIS_MSK = 32'h0000_000D,
  parameter logic [31:0]     CSCFG_VAL  = 32'h8000_0000,
  parameter int              RST_BIT    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] memSize,
  input  logic [DATA_W-1:0] pllStrap,
  input  logic [DATA_W-1:0] procVer,
  input  logic [DATA_W-1:0] sysVer,
  output logic [DATA_W-1:0] curBase,
  output logic [DATA_W-1:0] iackAddr,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              sysRstReq
);
  logic [DATA_W-1:0] errDis;
  logic [DATA_W-1:0] newBase;
  logic [DATA_W-1:0] rdMux;
  logic [DATA_W-1:0] bndsVal;

  assign newBase = (busWdata & BASE_MASK) << BASE_SHIFT;
  assign bndsVal = (memSize - 1'b1) >> BNDS_SHIFT;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBase  <= RESET_BASE;
      iackAddr <= RESET_BASE + IACK_OFS;
    end else if (strb.baseWr) begin
      curBase  <= newBase;
      iackAddr <= newBase + IACK_OFS;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) errDis <= '0;
    else if (strb.errDisWr) errDis <= busWdata & ERRDIS_MSK;
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_BASE:   rdMux = curBase >> BASE_SHIFT;
      SEL_BNDS:   rdMux = bndsVal;
      SEL_CSCFG:  rdMux = CSCFG_VAL;
      SEL_ERRDIS: rdMux = errDis;
      SEL_PLL:    rdMux = pllStrap;
      SEL_PVER:   rdMux = procVer;
      SEL_SVER:   rdMux = sysVer;
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      rspData   <= '0;
      sysRstReq <= 1'b0;
    end else begin
      rspValid  <= strb.claim;
      rspData   <= strb.isWrite ? '0 : rdMux;
      sysRstReq <= strb.rstWr && busWdata[RST_BIT];
    end
  end

endmodule

// File: rtl/relocwin_top.sv
module relocwin_top
  import relocwin_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int WIN_BITS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] memSize,
  input  logic [DATA_W-1:0] pllStrap,
  input  logic [DATA_W-1:0] procVer,
  input  logic [DATA_W-1:0] sysVer,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] iackAddr,
  output logic              sysRstReq
);
  strobe_t           strb;
  logic [ADDR_W-1:0] curBase;

  relocwin_ctrl #(.ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS)) u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .curBase  (curBase),
    .strb     (strb)
  );

  relocwin_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busWdata  (busWdata),
    .memSize   (memSize),
    .pllStrap  (pllStrap),
    .procVer   (procVer),
    .sysVer    (sysVer),
    .curBase   (curBase),
    .iackAddr  (iackAddr),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .sysRstReq (sysRstReq)
  );

endmodule

// File: rtl/relocwin_chk.sv
module relocwin_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic [31:0] busWdata,
  input logic        rspValid,
  input logic [31:0] iackAddr,
  input logic        sysRstReq
);
  // R2
  rsp_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(busValid));

  // R10
  rst_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |=> !sysRstReq);

  // R10
  rst_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> $past(busValid && busWrite && busWdata[1]));

  // R5
  iack_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    iackAddr[19:0] == 20'h400A0);

  // R4
  iack_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busValid && busWrite) |-> $stable(iackAddr));
endmodule

bind relocwin_top relocwin_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busValid  (busValid),
  .busWrite  (busWrite),
  .busWdata  (busWdata),
  .rspValid  (rspValid),
  .iackAddr  (iackAddr),
  .sysRstReq (sysRstReq)
);

// File: tb/sim_relocwin_top.sv
`timescale 1ns/1ps
module sim_relocwin_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0;
  logic [31:0] busAddr = '0, busWdata = '0;
  logic [31:0] memSize = 32'h4000_0000;
  logic [31:0] pllStrap = 32'h1234_5678;
  logic [31:0] procVer = 32'h8021_0030;
  logic [31:0] sysVer = 32'h8034_0011;
  logic        rspValid, sysRstReq;
  logic [31:0] rspData, iackAddr;

  int checks = 0, errors = 0;
  logic        gotV, gotR;
  logic [31:0] gotD;

  always #4 clk = ~clk;

  relocwin_top u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .memSize(memSize),
    .pllStrap(pllStrap), .procVer(procVer), .sysVer(sysVer),
    .rspValid(rspValid), .rspData(rspData), .iackAddr(iackAddr),
    .sysRstReq(sysRstReq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus access: driven at negedge, response sampled 1 ns after the next posedge
  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    gotV = rspValid; gotD = rspData; gotR = sysRstReq;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  // {wr, addr, wdata, expValid, expData}
  localparam int NV = 14;
  localparam logic [97:0] VEC [NV] = '{
    {1'b0, 32'hFF70_0000, 32'h0, 1'b1, 32'h000F_F700},  // R3
    {1'b0, 32'hFF70_2000, 32'h0, 1'b1, 32'h0000_003F},  // R6
    {1'b0, 32'hFF70_2080, 32'h0, 1'b1, 32'h8000_0000},  // R7
    {1'b0, 32'hFF70_2E40, 32'h0, 1'b1, 32'h0000_0000},  // R8
    {1'b1, 32'hFF70_2E44, 32'hFFFF_FFFF, 1'b1, 32'h0},  // R8 write
    {1'b0, 32'hFF70_2E44, 32'h0, 1'b1, 32'h0000_000D},  // R8
    {1'b1, 32'hFF70_2E44, 32'h0000_0006, 1'b1, 32'h0},  // R8 write
    {1'b0, 32'hFF70_2E44, 32'h0, 1'b1, 32'h0000_0004},  // R8
    {1'b0, 32'hFF7E_0000, 32'h0, 1'b1, 32'h1234_5678},  // R9
    {1'b0, 32'hFF7E_00A0, 32'h0, 1'b1, 32'h8021_0030},  // R9
    {1'b0, 32'hFF7E_00A4, 32'h0, 1'b1, 32'h8034_0011},  // R9
    {1'b0, 32'hFF70_1000, 32'h0, 1'b1, 32'h0},          // R11
    {1'b1, 32'hFF70_2E48, 32'hFFFF_FFFF, 1'b1, 32'h0},  // R11 write ignored
    {1'b0, 32'hFF80_0000, 32'h0, 1'b0, 32'h0}           // R2 outside window
  };

  initial begin
    #150000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    doReset();
    #1;
    chk("R1 base/iack", iackAddr, 32'hFF74_00A0);
    chk("R1 rspValid", {31'b0, rspValid}, 32'h0);
    chk("R1 sysRstReq", {31'b0, sysRstReq}, 32'h0);
    access(1'b0, 32'hFF70_2E44, 32'h0);
    chk("R1 errDis", gotD, 32'h0);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][97], VEC[i][96:65], VEC[i][64:33]);
      chk($sformatf("R2 valid vec%0d", i), {31'b0, gotV}, {31'b0, VEC[i][32]});
      if (VEC[i][32]) chk($sformatf("R2 data vec%0d", i), gotD, VEC[i][31:0]);
    end
    // R11 unmapped write left error disable unchanged
    access(1'b0, 32'hFF70_2E44, 32'h0);
    chk("R11 errDis kept", gotD, 32'h4);
    access(1'b0, 32'hFF70_2E48, 32'h0);
    chk("R11 unmapped read", gotD, 32'h0);

    // R4 relocation, next-cycle decode against new base
    access(1'b1, 32'hFF70_0000, 32'hABCD_EF12);
    #0 chk("R5 iack after move", iackAddr, 32'hDEF4_00A0);
    access(1'b0, 32'hDEF0_0000, 32'h0);
    chk("R4 new window claims", {31'b0, gotV}, 32'h1);
    chk("R4 base readback", gotD, 32'h000D_EF00);
    access(1'b0, 32'hFF70_0000, 32'h0);
    chk("R4 old window silent", {31'b0, gotV}, 32'h0);
    access(1'b0, 32'hDEFE_00A4, 32'h0);
    chk("R9 sysVer at new base", gotD, 32'h8034_0011);

    // R10 reset control
    access(1'b1, 32'hDEFE_00B0, 32'h0000_0002);
    chk("R10 pulse high", {31'b0, gotR}, 32'h1);
    @(posedge clk); #1;
    chk("R10 pulse one cycle", {31'b0, sysRstReq}, 32'h0);
    access(1'b1, 32'hDEFE_00B0, 32'hFFFF_FFFD);
    chk("R10 no pulse bit1 clear", {31'b0, gotR}, 32'h0);
    access(1'b0, 32'hDEFE_00B0, 32'h0);
    chk("R10 reads zero", gotD, 32'h0);

    // R6 bounds extremes
    memSize = 32'h0100_0000;
    access(1'b0, 32'hDEF0_2000, 32'h0);
    chk("R6 16MiB bounds", gotD, 32'h0);
    memSize = 32'h0;
    access(1'b0, 32'hDEF0_2000, 32'h0);
    chk("R6 zero size wraps", gotD, 32'hFF);

    // R1 reset restores defaults
    access(1'b1, 32'hDEF0_2E44, 32'h1);
    doReset();
    #1 chk("R1 iack after reset", iackAddr, 32'hFF74_00A0);
    access(1'b0, 32'hFF70_0000, 32'h0);
    chk("R1 base after reset", gotD, 32'h000F_F700);
    access(1'b0, 32'hFF70_2E44, 32'h0);
    chk("R1 errDis after reset", gotD, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule